// File: doc/BRIEF.md
# Hypervisor Exception Entry Unit

This block computes the entry side effects for an exception that a 32-bit processor takes into its hypervisor privilege level. The exception detection logic presents a type code together with a one-cycle valid strobe, the current privilege level, the preferred return address, the faulting virtual address, a syndrome word, three routing bits from the secure configuration (external abort, IRQ, FIQ) and the hypervisor vector base. One clock edge later the unit presents the new program counter, the new mode, the interrupt mask bits to set, and write strobes with data for the hypervisor syndrome register, the instruction-fault and data-fault address registers and the hypervisor link register.

The vector offset is chosen from the exception type. Synchronous entries whose offset lies below 0x14 use that offset only when the exception is taken from hypervisor level to hypervisor level. When the exception comes from any lower level they all share the 0x14 entry. The mask bits depend only on the routing bits. The saved return address is the preferred return address unchanged. A code outside the defined set raises an error pulse and blocks every update.

Top module: `hyp_exc_entry`

## Requirements
- R1: Exception codes on `req_code` are 0 undefined instruction, 1 supervisor call, 2 prefetch abort, 3 data abort, 4 IRQ, 5 FIQ, 6 hypervisor call, 7 hypervisor trap, 8 breakpoint. When `cur_el` is 2, the offsets are 0x04, 0x14, 0x0C, 0x10, 0x18, 0x1C, 0x08, 0x14 and 0x0C respectively, and `new_pc` equals the aligned vector base plus that offset.
- R2: A breakpoint takes offset 0x0C and captures `fault_va` into the instruction-fault register, exactly as a prefetch abort does.
- R3: When `cur_el` is not 2 and the offset from R1 is below 0x14, offset 0x14 is used instead. Offsets 0x14 and above are unchanged.
- R4: Bits [4:0] of `hvbar` have no effect on `new_pc`. Bits [4:0] of `new_pc` are the offset and bits [31:5] are `hvbar[31:5]`.
- R5: `mask_a`, `mask_i` and `mask_f` are set on entry to the inverse of `route_ea`, `route_irq` and `route_fiq` respectively.
- R6: `syn_we` pulses with `syn_data` equal to `syndrome` for every valid code except IRQ and FIQ. For IRQ and FIQ it stays low.
- R7: Prefetch abort and breakpoint pulse `ifar_we` with `ifar_data` equal to `fault_va`. Data abort pulses `dfar_we` with `dfar_data` equal to `fault_va`. No other code pulses either strobe.
- R8: Every valid entry pulses `lr_we` with `lr_data` equal to `pref_ret` plus zero, and sets `new_mode` to 5'h1A.
- R9: A code of 9 to 15 pulses `err` and leaves every strobe low and `new_pc`, `new_mode`, the masks and all data outputs unchanged.
- R10: All outputs change in the cycle after the `req_valid` cycle. Each strobe lasts exactly one cycle, and no strobe rises without a request.
- R11: While reset is held, and until the first request after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle exception request strobe |
| req_code | input | 4 | Exception type code |
| cur_el | input | 2 | Current privilege level (2 = hypervisor) |
| pref_ret | input | 32 | Preferred return address |
| fault_va | input | 32 | Faulting virtual address |
| syndrome | input | 32 | Syndrome word |
| route_ea | input | 1 | External-abort routing bit |
| route_irq | input | 1 | IRQ routing bit |
| route_fiq | input | 1 | FIQ routing bit |
| hvbar | input | 32 | Hypervisor vector base |
| entry_valid | output | 1 | Entry taken, PC and mode updated |
| new_pc | output | 32 | Target program counter |
| new_mode | output | 5 | New processor mode |
| mask_a | output | 1 | Asynchronous-abort mask to set |
| mask_i | output | 1 | IRQ mask to set |
| mask_f | output | 1 | FIQ mask to set |
| syn_we | output | 1 | Syndrome register write strobe |
| syn_data | output | 32 | Syndrome register data |
| ifar_we | output | 1 | Instruction-fault address write strobe |
| ifar_data | output | 32 | Instruction-fault address data |
| dfar_we | output | 1 | Data-fault address write strobe |
| dfar_data | output | 32 | Data-fault address data |
| lr_we | output | 1 | Link register write strobe |
| lr_data | output | 32 | Saved return address |
| err | output | 1 | Unrecognised exception code |

## Verification
All state here is one stage deep, so a wrong decode, a wrong funnel choice or a stale enable shows at the ports on the clock edge right after the request. It appears as a bad low-order offset in `new_pc`, a missing or extra strobe, or held data that moved when it should not have. Hold behaviour is observed through the outputs in the idle cycles between requests: a register that drifts without a strobe differs on the very next cycle. Invalid codes are placed between valid ones, so any leak past the error path shows as a changed `new_pc` or data output.

// File: rtl/hyp_exc_pkg.sv
package hyp_exc_pkg;
  localparam int CODE_W = 4;
  localparam int OFF_W  = 5;
  localparam int EL_W   = 2;
  localparam logic [EL_W-1:0] HYP_EL  = 2'd2;
  localparam logic [4:0]      MODE_HYP = 5'h1A;
  localparam logic [OFF_W-1:0] OFF_SHARED = 5'h14;

  typedef enum logic [CODE_W-1:0] {
    EXC_UNDEF = 4'd0,
    EXC_SVC   = 4'd1,
    EXC_PABT  = 4'd2,
    EXC_DABT  = 4'd3,
    EXC_IRQ   = 4'd4,
    EXC_FIQ   = 4'd5,
    EXC_HVC   = 4'd6,
    EXC_HTRAP = 4'd7,
    EXC_BKPT  = 4'd8
  } exc_code_e;

  typedef struct packed {
    logic             known;
    logic [OFF_W-1:0] off;
    logic             syn_wr;
    logic             ifar_wr;
    logic             dfar_wr;
  } exc_dec_t;
endpackage

// File: rtl/hyp_rst_sync.sv
module hyp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hyp_vec_decode.sv
module hyp_vec_decode
  import hyp_exc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [EL_W-1:0]   cur_el,
  output exc_dec_t          dec
);
  logic [OFF_W-1:0] raw_off;
  logic             known;
  logic             is_irq_fiq;
  logic             is_inst_fault;
  logic             is_data_fault;

  always_comb begin
    known         = 1'b1;
    raw_off       = '0;
    is_irq_fiq    = 1'b0;
    is_inst_fault = 1'b0;
    is_data_fault = 1'b0;
    case (code)
      EXC_UNDEF: raw_off = 5'h04;
      EXC_HVC:   raw_off = 5'h08;
      EXC_PABT,
      EXC_BKPT: begin
        raw_off       = 5'h0C;
        is_inst_fault = 1'b1;
      end
      EXC_DABT: begin
        raw_off       = 5'h10;
        is_data_fault = 1'b1;
      end
      EXC_SVC,
      EXC_HTRAP: raw_off = 5'h14;
      EXC_IRQ: begin
        raw_off    = 5'h18;
        is_irq_fiq = 1'b1;
      end
      EXC_FIQ: begin
        raw_off    = 5'h1C;
        is_irq_fiq = 1'b1;
      end
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    dec.known   = known;
    dec.off     = ((cur_el != HYP_EL) && (raw_off < OFF_SHARED)) ? OFF_SHARED : raw_off;
    dec.syn_wr  = known && !is_irq_fiq;
    dec.ifar_wr = is_inst_fault;
    dec.dfar_wr = is_data_fault;
  end
endmodule

// File: rtl/hyp_mask_gen.sv
module hyp_mask_gen (
  input  logic       route_ea,
  input  logic       route_irq,
  input  logic       route_fiq,
  output logic [2:0] mask_afi
);
  always_comb begin
    mask_afi[2] = !route_ea;
    mask_afi[1] = !route_irq;
    mask_afi[0] = !route_fiq;
  end
endmodule

// File: rtl/hyp_entry_regs.sv
module hyp_entry_regs
  import hyp_exc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SYN_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  exc_dec_t          dec,
  input  logic [2:0]        mask_afi,
  input  logic [ADDR_W-1:0] vec_base,
  input  logic [ADDR_W-1:0] pref_ret,
  input  logic [ADDR_W-1:0] fault_va,
  input  logic [SYN_W-1:0]  syndrome,
  output logic              entry_valid,
  output logic [ADDR_W-1:0] new_pc,
  output logic [4:0]        new_mode,
  output logic [2:0]        mask_q,
  output logic              syn_we,
  output logic [SYN_W-1:0]  syn_data,
  output logic              ifar_we,
  output logic [ADDR_W-1:0] ifar_data,
  output logic              dfar_we,
  output logic [ADDR_W-1:0] dfar_data,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_data,
  output logic              err
);
  logic              fire;
  logic              syn_en, ifar_en, dfar_en, bad_code;
  logic [ADDR_W-1:0] pc_nxt;
  logic [ADDR_W-1:0] lr_nxt;

  always_comb begin
    fire     = req_valid && dec.known;
    bad_code = req_valid && !dec.known;
    syn_en   = fire && dec.syn_wr;
    ifar_en  = fire && dec.ifar_wr;
    dfar_en  = fire && dec.dfar_wr;
    pc_nxt   = {vec_base[ADDR_W-1:OFF_W], dec.off};
    lr_nxt   = pref_ret + {ADDR_W{1'b0}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_valid <= 1'b0;
      syn_we      <= 1'b0;
      ifar_we     <= 1'b0;
      dfar_we     <= 1'b0;
      lr_we       <= 1'b0;
      err         <= 1'b0;
    end else begin
      entry_valid <= fire;
      syn_we      <= syn_en;
      ifar_we     <= ifar_en;
      dfar_we     <= dfar_en;
      lr_we       <= fire;
      err         <= bad_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_pc   <= '0;
      new_mode <= '0;
      mask_q   <= '0;
      lr_data  <= '0;
    end else if (fire) begin
      new_pc   <= pc_nxt;
      new_mode <= MODE_HYP;
      mask_q   <= mask_afi;
      lr_data  <= lr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      syn_data <= '0;
    else if (syn_en) syn_data <= syndrome;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ifar_data <= '0;
    else if (ifar_en) ifar_data <= fault_va;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dfar_data <= '0;
    else if (dfar_en) dfar_data <= fault_va;
  end
endmodule

// File: rtl/hyp_exc_entry.sv
module hyp_exc_entry
  import hyp_exc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SYN_W     = 32,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic [EL_W-1:0]   cur_el,
  input  logic [ADDR_W-1:0] pref_ret,
  input  logic [ADDR_W-1:0] fault_va,
  input  logic [SYN_W-1:0]  syndrome,
  input  logic              route_ea,
  input  logic              route_irq,
  input  logic              route_fiq,
  input  logic [ADDR_W-1:0] hvbar,
  output logic              entry_valid,
  output logic [ADDR_W-1:0] new_pc,
  output logic [4:0]        new_mode,
  output logic              mask_a,
  output logic              mask_i,
  output logic              mask_f,
  output logic              syn_we,
  output logic [SYN_W-1:0]  syn_data,
  output logic              ifar_we,
  output logic [ADDR_W-1:0] ifar_data,
  output logic              dfar_we,
  output logic [ADDR_W-1:0] dfar_data,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_data,
  output logic              err
);
  localparam int VEC_LSB = OFF_W;

  logic              rst_n_int;
  exc_dec_t          dec;
  logic [2:0]        mask_afi;
  logic [2:0]        mask_q;
  logic [ADDR_W-1:0] vec_base;

  assign vec_base = {hvbar[ADDR_W-1:VEC_LSB], {VEC_LSB{1'b0}}};

  hyp_rst_sync #(.STAGES(RST_STAGE)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hyp_vec_decode dec_i (
    .code   (req_code),
    .cur_el (cur_el),
    .dec    (dec)
  );

  hyp_mask_gen mask_i_u (
    .route_ea  (route_ea),
    .route_irq (route_irq),
    .route_fiq (route_fiq),
    .mask_afi  (mask_afi)
  );

  hyp_entry_regs #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req_valid   (req_valid),
    .dec         (dec),
    .mask_afi    (mask_afi),
    .vec_base    (vec_base),
    .pref_ret    (pref_ret),
    .fault_va    (fault_va),
    .syndrome    (syndrome),
    .entry_valid (entry_valid),
    .new_pc      (new_pc),
    .new_mode    (new_mode),
    .mask_q      (mask_q),
    .syn_we      (syn_we),
    .syn_data    (syn_data),
    .ifar_we     (ifar_we),
    .ifar_data   (ifar_data),
    .dfar_we     (dfar_we),
    .dfar_data   (dfar_data),
    .lr_we       (lr_we),
    .lr_data     (lr_data),
    .err         (err)
  );

  assign mask_a = mask_q[2];
  assign mask_i = mask_q[1];
  assign mask_f = mask_q[0];
endmodule

// File: rtl/hyp_exc_entry_chk.sv
module hyp_exc_entry_chk #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [3:0]        req_code,
  input logic [1:0]        cur_el,
  input logic [ADDR_W-1:0] pref_ret,
  input logic [ADDR_W-1:0] hvbar,
  input logic              route_ea,
  input logic              route_irq,
  input logic              route_fiq,
  input logic              entry_valid,
  input logic [ADDR_W-1:0] new_pc,
  input logic [4:0]        new_mode,
  input logic              mask_a,
  input logic              mask_i,
  input logic              mask_f,
  input logic              syn_we,
  input logic              ifar_we,
  input logic              dfar_we,
  input logic              lr_we,
  input logic [ADDR_W-1:0] lr_data,
  input logic              err
);
  assert_strobe_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid || err) |-> $past(req_valid));

  assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(entry_valid || syn_we || ifar_we || dfar_we || lr_we));

  assert_err_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(new_pc));

  assert_far_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifar_we && dfar_we));

  assert_shared_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && $past(cur_el) != 2'd2) |-> new_pc[4:0] >= 5'h14);

  assert_base_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> (new_pc[ADDR_W-1:5] == $past(hvbar[ADDR_W-1:5])) && (new_pc[1:0] == 2'b00));

  assert_mask_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> (mask_a == !$past(route_ea)) && (mask_i == !$past(route_irq))
                    && (mask_f == !$past(route_fiq)));

  assert_lr_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> (lr_data == $past(pref_ret)) && (new_mode == 5'h1A));

  assert_no_syn_async_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && ($past(req_code) == 4'd4 || $past(req_code) == 4'd5)) |-> !syn_we);
endmodule

bind hyp_exc_entry hyp_exc_entry_chk #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
  .cur_el(cur_el), .pref_ret(pref_ret), .hvbar(hvbar), .route_ea(route_ea),
  .route_irq(route_irq), .route_fiq(route_fiq), .entry_valid(entry_valid),
  .new_pc(new_pc), .new_mode(new_mode), .mask_a(mask_a), .mask_i(mask_i),
  .mask_f(mask_f), .syn_we(syn_we), .ifar_we(ifar_we), .dfar_we(dfar_we),
  .lr_we(lr_we), .lr_data(lr_data), .err(err)
);

// File: tb/hyp_exc_entry_tb.sv
module hyp_exc_entry_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_code = '0;
  logic [1:0]  cur_el = '0;
  logic [31:0] pref_ret = '0, fault_va = '0, syndrome = '0, hvbar = '0;
  logic        route_ea = 1'b0, route_irq = 1'b0, route_fiq = 1'b0;

  logic        entry_valid, mask_a, mask_i, mask_f;
  logic        syn_we, ifar_we, dfar_we, lr_we, err;
  logic [31:0] new_pc, syn_data, ifar_data, dfar_data, lr_data;
  logic [4:0]  new_mode;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hyp_exc_entry dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .cur_el(cur_el), .pref_ret(pref_ret), .fault_va(fault_va), .syndrome(syndrome),
    .route_ea(route_ea), .route_irq(route_irq), .route_fiq(route_fiq), .hvbar(hvbar),
    .entry_valid(entry_valid), .new_pc(new_pc), .new_mode(new_mode),
    .mask_a(mask_a), .mask_i(mask_i), .mask_f(mask_f),
    .syn_we(syn_we), .syn_data(syn_data), .ifar_we(ifar_we), .ifar_data(ifar_data),
    .dfar_we(dfar_we), .dfar_data(dfar_data), .lr_we(lr_we), .lr_data(lr_data),
    .err(err)
  );

  // Behavioural reference: expected outputs, updated on each rising edge
  logic        m_ev, m_syw, m_ifw, m_dfw, m_lrw, m_err, m_a, m_i, m_f;
  logic [31:0] m_pc, m_syn, m_if, m_df, m_lr;
  logic [4:0]  m_mode;

  function automatic int vec_off(input int code, input int el);
    int off;
    case (code)
      0: off = 'h04; 1: off = 'h14; 2: off = 'h0C; 3: off = 'h10;
      4: off = 'h18; 5: off = 'h1C; 6: off = 'h08; 7: off = 'h14;
      8: off = 'h0C; default: off = -1;
    endcase
    if (off >= 0 && el != 2 && off < 'h14) off = 'h14;
    return off;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ev, m_syw, m_ifw, m_dfw, m_lrw, m_err, m_a, m_i, m_f} <= '0;
      m_pc <= 0; m_syn <= 0; m_if <= 0; m_df <= 0; m_lr <= 0; m_mode <= 0;
    end else begin
      int off;
      off = vec_off(int'(req_code), int'(cur_el));
      {m_ev, m_syw, m_ifw, m_dfw, m_lrw, m_err} <= '0;
      if (req_valid && off < 0) m_err <= 1'b1;
      if (req_valid && off >= 0) begin
        m_ev <= 1; m_lrw <= 1;
        m_pc <= (hvbar & 32'hFFFF_FFE0) + 32'(off);
        m_mode <= 5'h1A;
        m_a <= !route_ea; m_i <= !route_irq; m_f <= !route_fiq;
        m_lr <= pref_ret;
        if (req_code != 4 && req_code != 5) begin m_syw <= 1; m_syn <= syndrome; end
        if (req_code == 2 || req_code == 8) begin m_ifw <= 1; m_if <= fault_va; end
        if (req_code == 3) begin m_dfw <= 1; m_df <= fault_va; end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R10", "entry_valid", 32'(entry_valid), 32'(m_ev));
      chk("R9",  "err",         32'(err),         32'(m_err));
      chk("R1",  "new_pc",      new_pc,           m_pc);
      chk("R8",  "new_mode",    32'(new_mode),    32'(m_mode));
      chk("R5",  "masks",       32'({mask_a, mask_i, mask_f}), 32'({m_a, m_i, m_f}));
      chk("R6",  "syn_we",      32'(syn_we),      32'(m_syw));
      chk("R6",  "syn_data",    syn_data,         m_syn);
      chk("R7",  "ifar_we",     32'(ifar_we),     32'(m_ifw));
      chk("R7",  "ifar_data",   ifar_data,        m_if);
      chk("R7",  "dfar_we",     32'(dfar_we),     32'(m_dfw));
      chk("R7",  "dfar_data",   dfar_data,        m_df);
      chk("R8",  "lr_we",       32'(lr_we),       32'(m_lrw));
      chk("R8",  "lr_data",     lr_data,          m_lr);
    end
  end

  task automatic send(input int code, input int el, input logic [31:0] base,
                      input logic [2:0] route, input logic [31:0] seed);
    @(negedge clk); #1;
    req_valid = 1; req_code = 4'(code); cur_el = 2'(el); hvbar = base;
    {route_ea, route_irq, route_fiq} = route;
    pref_ret = seed ^ 32'h1111_0000; fault_va = seed ^ 32'h0000_F00D; syndrome = seed + 32'h77;
    @(negedge clk); #1;
    req_valid = 0;
    // Inputs change while idle: outputs must hold (R10, R9)
    pref_ret = ~pref_ret; fault_va = ~fault_va; syndrome = ~syndrome; hvbar = ~hvbar;
  endtask

  // Directed check at the ports for a named case
  task automatic expect_pc(input string req, input logic [31:0] exp);
    @(negedge clk); #2;
    chk(req, "directed new_pc", new_pc, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs zero while reset held
    chk("R11", "reset pc", new_pc, 32'h0);
    chk("R11", "reset strobes", 32'({entry_valid, syn_we, ifar_we, dfar_we, lr_we, err}), 32'h0);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R11", "post-reset lr", lr_data, 32'h0);

    // R1, R2: every code from hypervisor level, base with low bits set (R4)
    for (int c = 0; c < 16; c++) send(c, 2, 32'h8000_101F, 3'(c), 32'(c) * 32'h0101_0101);
    // R3: same codes from lower levels
    for (int el = 0; el < 2; el++)
      for (int c = 0; c < 16; c++) send(c, el, 32'h4000_2000 | 32'(c), 3'(c + el), 32'hABC0_0000 + 32'(c));

    // Directed corners
    req_valid = 0;
    @(negedge clk); #1;
    req_valid = 1; req_code = 4'd8; cur_el = 2'd2; hvbar = 32'hFFFF_FFFF; fault_va = 32'hDEAD_BEEF;
    @(negedge clk); #1 req_valid = 0;
    chk("R2", "bkpt ifar", ifar_data, 32'hDEAD_BEEF);
    chk("R4", "bkpt pc low bits", new_pc, 32'hFFFF_FFEC);
    req_valid = 1; req_code = 4'd0; cur_el = 2'd1; hvbar = 32'h0000_0040;
    @(negedge clk); #1 req_valid = 0;
    chk("R3", "undef from lower level", new_pc, 32'h0000_0054);
    req_valid = 1; req_code = 4'd15; hvbar = 32'h0;
    @(negedge clk); #1 req_valid = 0;
    chk("R9", "invalid err", 32'(err), 32'h1);
    chk("R9", "invalid pc hold", new_pc, 32'h0000_0054);
    expect_pc("R10", 32'h0000_0054);

    // Pseudo-random sweep
    for (int k = 0; k < 400; k++)
      send(int'($urandom_range(0, 15)), int'($urandom_range(0, 3)), $urandom,
           3'($urandom_range(0, 7)), $urandom);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule